// File: doc/BRIEF.md
# Four-Word Register File with Gated Ports

This block holds four words of four bits each and offers one write port and one read port that work independently in the same cycle. The write port takes a two-bit word select, four data bits and an active-low write strobe; the selected word takes the data on the rising clock edge while the strobe is low. The read port takes its own two-bit word select and an active-low read strobe. While that strobe is low, the selected word is driven onto a tri-state output bus. While it is high, the bus floats.

Reads are combinational from storage. When a read and a write address the same word in one cycle, the read shows the old contents until the edge and the new contents after it. A synchronous reset clears all words to zero. Typical use is a small scratch store placed on a shared bus, where another driver uses the output lines while the read strobe is off.

Top module: `gated_regfile4x4`

## Requirements
- R1: The file holds exactly four words of four bits. A synchronous reset (rst high at a rising edge) sets all four words to 0000.
- R2: On a rising edge with wr_n low and no reset, the word at index wr_sel (wr_sel[1] is the high bit, so 2'b01 is word 1) takes the value of wr_data.
- R3: On a rising edge with wr_n high, no word changes, whatever wr_sel and wr_data are.
- R4: While rd_n is low, rd_q equals the word at index rd_sel (rd_sel[1] is the high bit, so 2'b10 is word 2), with no clock cycle of delay.
- R5: While rd_n is high, all four bits of rd_q are high impedance (z).
- R6: A write to one word leaves the other three words unchanged.
- R7: A read and a write may happen in the same cycle. When their indices match, rd_q shows the old word before the edge and the written word after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all words |
| wr_n | input | 1 | Write strobe, active low |
| wr_sel | input | 2 | Index of the word to write |
| wr_data | input | 4 | Data to write |
| rd_n | input | 1 | Read strobe, active low; when high the output floats |
| rd_sel | input | 2 | Index of the word to read |
| rd_q | output | 4 | Tri-state read data |

## Verification
A write becomes visible one edge after it is presented. The bench drives the inputs on the falling edge, lets the rising edge pass and reads rd_q in the following low phase. Reads have no clock delay. Their checks therefore sample rd_q a short settle time after the bench changes rd_sel or rd_n, in the same half cycle. For the same-index case, the bench checks the old value before the edge and the new value after it. A reference array updated at each write gives every expected word, and a float check compares rd_q to 4'bzzzz with the case-equality operator.

// File: rtl/gated_regfile4x4.sv
module gated_regfile4x4 #(
  parameter int WORDS = 4,
  parameter int WIDTH = 4,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic [AW-1:0]    wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_n,
  input  logic [AW-1:0]    rd_sel,
  output tri   [WIDTH-1:0] rd_q
);

  logic [WIDTH-1:0] mem [WORDS];
  logic [WIDTH-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (!wr_n) begin
      mem[wr_sel] <= wr_data;
    end
  end

  assign rd_word = mem[rd_sel];
  assign rd_q = rd_n ? {WIDTH{1'bz}} : rd_word;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R1
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (mem[0] == '0 && mem[WORDS-1] == '0));

  // R2
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !wr_n) |=> (mem[$past(wr_sel)] == $past(wr_data)));

  // R3
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && wr_n) |=> (mem[0] == $past(mem[0]) && mem[WORDS-1] == $past(mem[WORDS-1])));

  // R6
  p_other_words_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !wr_n && wr_sel != rd_sel) |=>
      (mem[$past(rd_sel)] == $past(mem[rd_sel])));

  // R4, R5
  always_comb begin
    if (!$isunknown(rd_n) && !$isunknown(rd_sel)) begin
      a_read_path_r4: assert (rd_n || rd_q === mem[rd_sel]);
    end
  end

endmodule

// File: tb/gated_regfile4x4_tb.sv
`timescale 1ns/1ps
module gated_regfile4x4_tb;
  logic clk = 0, rst = 1, wr_n = 1, rd_n = 1;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [3:0] wr_data = 0;
  wire  [3:0] rd_q;
  logic [3:0] ref_m [4];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gated_regfile4x4 u_dut (.clk(clk), .rst(rst), .wr_n(wr_n), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_n(rd_n), .rd_sel(rd_sel), .rd_q(rd_q));

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if (rd_q !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, rd_q, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    rd_n = 0; rd_sel = a; #2;
    chk(req, ref_m[a]);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); wr_n = 0; wr_sel = a; wr_data = d;
    @(negedge clk); wr_n = 1; ref_m[a] = d;
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    for (int i = 0; i < 4; i++) ref_m[i] = 0;
    for (int i = 0; i < 4; i++) rd(i[1:0], "R1");
  endtask

  task automatic t_write_read;
    wr(2'b01, 4'hA); rd(2'b01, "R2");
    wr(2'b10, 4'h5); rd(2'b10, "R4");
    wr(2'b00, 4'hF); wr(2'b11, 4'h3);
    for (int i = 0; i < 4; i++) rd(i[1:0], "R6");
  endtask

  task automatic t_no_write;
    @(negedge clk); wr_n = 1; wr_sel = 2'b10; wr_data = 4'hC;
    @(negedge clk);
    for (int i = 0; i < 4; i++) rd(i[1:0], "R3");
  endtask

  task automatic t_float;
    rd_n = 1; #2; chk("R5", 4'bzzzz);
    rd_sel = 2'b11; #2; chk("R5", 4'bzzzz);
    rd(2'b11, "R4");
  endtask

  task automatic t_same_cycle;
    @(negedge clk); rd_n = 0; rd_sel = 2'b10;
    wr_n = 0; wr_sel = 2'b10; wr_data = 4'h9; #2;
    chk("R7", ref_m[2]);
    @(negedge clk); wr_n = 1; ref_m[2] = 4'h9; #2;
    chk("R7", 4'h9);
    @(negedge clk); rd_sel = 2'b00; wr_n = 0; wr_sel = 2'b01; wr_data = 4'h6; #2;
    chk("R7", ref_m[0]);
    @(negedge clk); wr_n = 1; ref_m[1] = 4'h6;
    rd(2'b01, "R7"); rd(2'b00, "R6");
  endtask

  initial begin
    fork
      begin
        t_reset; t_write_read; t_no_write; t_float; t_same_cycle;
        t_reset;
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule